// File: doc/BRIEF.md
# Dark-Row Black Level Corrector

This block sits in a raw Bayer pixel stream and removes the black offset that a sensor adds to every pixel. A sensor outputs a few shielded rows in each frame. The block treats a configured band of those rows as a dark reference. For each of the four colour phases it collects samples from those rows, averages them over a power-of-two number of frames, and subtracts the resulting per-phase offset from every delivered pixel. The result is clamped at zero.

The dark band is stripped from the output stream. The outgoing frame-start and line-end markers are rebuilt so that downstream stages see only image rows. The offsets are also brought out as a port so they can be read. A newly measured set takes effect exactly at a frame start, so a single frame never mixes two offset sets. Measurement runs continuously: each integration period produces a fresh set that replaces the last one.

Top module: `dark_offset_sub`

## Requirements
- R1: Rows whose index r satisfies cfgDarkStart <= r < cfgDarkStart + cfgDarkCount are never delivered (outValid stays 0 for them). Every other valid input pixel appears on the output exactly one clock later. Row 0 is the row carrying inSof, and the row index advances after each inEol pixel.
- R2: outSof is raised on the first delivered pixel of each frame, including when row 0 is dark. outEol is raised on a delivered pixel exactly when its input had inEol.
- R3: The colour channel of a pixel is cfgPhase XOR {row[0], col[0]}, with 0 = red, 1 = green in red rows, 2 = green in blue rows and 3 = blue. The column resets to 0 at inSof and after inEol. The offset for channel i is on offsetsOut[i*PIX_W +: PIX_W].
- R4: In each frame, each channel accumulates only its first 2^cfgWinLog2 pixels that fall in dark rows. Further dark pixels of that channel in the same frame are ignored.
- R5: Integration starts at the first frame start seen while enabled. After 2^cfgIntLog2 frames, the next frame start publishes, for each channel, floor(sum / 2^(cfgIntLog2 + cfgWinLog2)) as the new offset.
- R6: Offsets change only on a frame-start pixel or on disable. A published set already applies to the pixel that carries inSof.
- R7: A delivered pixel equals max(input - offset[channel], 0) and never wraps.
- R8: While cfgEnable is 0, all offsets are held at zero, no samples are collected and pixels pass through unchanged (the dark band is still stripped). Re-enabling starts a fresh integration.
- R9: After reset, outValid, outSof, outEol and all offsets are zero.
- R10: Integration periods follow one another without a gap. Each publish replaces the previous offsets with values from the new period only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present |
| inSof | input | 1 | Input pixel is the first of a frame |
| inEol | input | 1 | Input pixel is the last of a line |
| inData | input | PIX_W | Raw pixel value |
| cfgEnable | input | 1 | Measurement and correction on |
| cfgPhase | input | 2 | Channel of the first pixel in a frame |
| cfgDarkStart | input | ROW_W | First dark row index |
| cfgDarkCount | input | ROW_W | Number of dark rows |
| cfgIntLog2 | input | INT_SEL_W | log2 of frames per integration period |
| cfgWinLog2 | input | WIN_SEL_W | log2 of samples per channel per frame |
| outValid | output | 1 | Output pixel present |
| outSof | output | 1 | First delivered pixel of a frame |
| outEol | output | 1 | Last delivered pixel of a line |
| outData | output | PIX_W | Corrected pixel |
| offsetsOut | output | 4*PIX_W | Current offsets, channel i in lane i |

## Verification
Some properties are checked on every cycle. No delivered pixel exceeds the input it came from. Output markers appear only on valid output. Offsets hold steady between frame starts while enabled, and they read zero one cycle after disable. Other behaviour only shows up in the bench's scenarios against its own model: which rows are stripped, where the frame start is re-placed, the phase-to-channel mapping, the sample window cut-off, and the exact averages published over several consecutive integration periods.

// File: rtl/dark_offset_pkg.sv
package dark_offset_pkg;

  localparam int NUM_CH = 4;

  // strobes from control to datapath, one set per input cycle
  typedef struct packed {
    logic       keep;        // pixel is delivered (valid and not dark)
    logic       sof;         // delivered pixel carries the rebuilt frame start
    logic       eol;         // delivered pixel ends a line
    logic       measure;     // integration running for this pixel
    logic       dark;        // pixel lies in the dark band
    logic [1:0] ch;          // colour channel of this pixel
    logic       frameStart;  // valid pixel with inSof
    logic       restart;     // accumulators start over with this pixel
    logic       publish;     // accumulators turn into offsets now
    logic       disabled;    // block switched off
  } ctrlStrb_t;

endpackage

// File: rtl/dark_offset_ctrl.sv
module dark_offset_ctrl
  import dark_offset_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int INT_LOG2_MAX = 7,
  localparam int INT_SEL_W   = $clog2(INT_LOG2_MAX + 1),
  localparam int FRM_W       = INT_LOG2_MAX + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inEol,
  input  logic                 cfgEnable,
  input  logic [1:0]           cfgPhase,
  input  logic [ROW_W-1:0]     cfgDarkStart,
  input  logic [ROW_W-1:0]     cfgDarkCount,
  input  logic [INT_SEL_W-1:0] cfgIntLog2,
  output ctrlStrb_t            strb
);

  logic [ROW_W-1:0] rowCnt, rowCur;
  logic             colPar, colCur;
  logic [ROW_W:0]   darkEnd;
  logic             isDark, frameStart, sofPending;
  logic             armed, publish;
  logic [FRM_W-1:0] framesDone, framesNext, target;

  // position of the current pixel; inSof forces row and column to zero
  assign rowCur = inSof ? '0 : rowCnt;
  assign colCur = inSof ? 1'b0 : colPar;

  assign darkEnd = {1'b0, cfgDarkStart} + {1'b0, cfgDarkCount};
  assign isDark  = ({1'b0, rowCur} >= {1'b0, cfgDarkStart}) && ({1'b0, rowCur} < darkEnd);

  assign frameStart = inValid & inSof;
  assign target     = FRM_W'(1) << cfgIntLog2;
  assign framesNext = framesDone + FRM_W'(1);
  assign publish    = frameStart & cfgEnable & armed & (framesNext == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowCnt <= '0;
      colPar <= 1'b0;
    end else if (inValid) begin
      if (inEol) begin
        rowCnt <= rowCur + ROW_W'(1);
        colPar <= 1'b0;
      end else begin
        rowCnt <= rowCur;
        colPar <= ~colCur;
      end
    end
  end

  // frame start of the delivered stream waits for the first non-dark pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sofPending <= 1'b0;
    end else if (inValid && !isDark) begin
      sofPending <= 1'b0;
    end else if (frameStart) begin
      sofPending <= 1'b1;
    end
  end

  // integration period bookkeeping in frames
  always_ff @(posedge clk) begin
    if (!rst_n || !cfgEnable) begin
      armed      <= 1'b0;
      framesDone <= '0;
    end else if (frameStart) begin
      if (!armed) begin
        armed      <= 1'b1;
        framesDone <= '0;
      end else if (publish) begin
        framesDone <= '0;
      end else begin
        framesDone <= framesNext;
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.keep       = inValid & ~isDark;
    strb.sof        = inValid & ~isDark & (inSof | sofPending);
    strb.eol        = inValid & ~isDark & inEol;
    strb.measure    = inValid & cfgEnable & (armed | frameStart);
    strb.dark       = isDark;
    strb.ch         = cfgPhase ^ {rowCur[0], colCur};
    strb.frameStart = frameStart;
    strb.restart    = frameStart & cfgEnable & (~armed | publish);
    strb.publish    = publish;
    strb.disabled   = ~cfgEnable;
  end

endmodule

// File: rtl/dark_offset_dp.sv
module dark_offset_dp
  import dark_offset_pkg::*;
#(
  parameter int PIX_W        = 12,
  parameter int INT_LOG2_MAX = 7,
  parameter int WIN_LOG2_MAX = 8,
  localparam int INT_SEL_W   = $clog2(INT_LOG2_MAX + 1),
  localparam int WIN_SEL_W   = $clog2(WIN_LOG2_MAX + 1),
  localparam int ACC_W       = PIX_W + INT_LOG2_MAX + WIN_LOG2_MAX,
  localparam int CNT_W       = WIN_LOG2_MAX + 1,
  localparam int SH_W        = ((INT_SEL_W > WIN_SEL_W) ? INT_SEL_W : WIN_SEL_W) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrb_t                 strb,
  input  logic [PIX_W-1:0]          inData,
  input  logic [INT_SEL_W-1:0]      cfgIntLog2,
  input  logic [WIN_SEL_W-1:0]      cfgWinLog2,
  output logic                      outValid,
  output logic                      outSof,
  output logic                      outEol,
  output logic [PIX_W-1:0]          outData,
  output logic [NUM_CH*PIX_W-1:0]   offsetsOut
);

  logic [NUM_CH-1:0][PIX_W-1:0] offVec, newVec;
  logic [SH_W-1:0]              shiftAmt;
  logic [CNT_W-1:0]             windowSize;
  logic [PIX_W-1:0]             chosenOff, clipped;
  logic [PIX_W:0]               diff;

  assign shiftAmt   = SH_W'(cfgIntLog2) + SH_W'(cfgWinLog2);
  assign windowSize = CNT_W'(1) << cfgWinLog2;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [CNT_W-1:0] sampCnt;
    logic [ACC_W-1:0] acc;
    logic [PIX_W-1:0] offReg;
    logic             take;

    // a new frame empties the window, so its first sample is always taken
    assign take = strb.measure & strb.dark & (strb.ch == 2'(g)) &
                  (strb.frameStart | (sampCnt < windowSize));

    always_ff @(posedge clk) begin
      if (!rst_n || strb.disabled) begin
        sampCnt <= '0;
        acc     <= '0;
        offReg  <= '0;
      end else begin
        if (strb.frameStart) begin
          sampCnt <= take ? CNT_W'(1) : '0;
        end else if (take) begin
          sampCnt <= sampCnt + CNT_W'(1);
        end
        if (strb.restart) begin
          acc <= take ? ACC_W'(inData) : '0;
        end else if (take) begin
          acc <= acc + ACC_W'(inData);
        end
        if (strb.publish) begin
          offReg <= newVec[g];
        end
      end
    end

    assign newVec[g] = PIX_W'(acc >> shiftAmt);
    assign offVec[g] = offReg;
  end

  assign offsetsOut = offVec;

  // a set published on this pixel already corrects it
  assign chosenOff = strb.publish ? newVec[strb.ch] : offVec[strb.ch];
  assign diff      = {1'b0, inData} - {1'b0, chosenOff};
  assign clipped   = diff[PIX_W] ? '0 : diff[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.keep;
      outSof   <= strb.sof;
      outEol   <= strb.eol;
      outData  <= strb.keep ? clipped : '0;
    end
  end

endmodule

// File: rtl/dark_offset_sub.sv
module dark_offset_sub
  import dark_offset_pkg::*;
#(
  parameter int PIX_W        = 12,
  parameter int ROW_W        = 11,
  parameter int INT_LOG2_MAX = 7,
  parameter int WIN_LOG2_MAX = 8,
  localparam int INT_SEL_W   = $clog2(INT_LOG2_MAX + 1),
  localparam int WIN_SEL_W   = $clog2(WIN_LOG2_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic                    inSof,
  input  logic                    inEol,
  input  logic [PIX_W-1:0]        inData,
  input  logic                    cfgEnable,
  input  logic [1:0]              cfgPhase,
  input  logic [ROW_W-1:0]        cfgDarkStart,
  input  logic [ROW_W-1:0]        cfgDarkCount,
  input  logic [INT_SEL_W-1:0]    cfgIntLog2,
  input  logic [WIN_SEL_W-1:0]    cfgWinLog2,
  output logic                    outValid,
  output logic                    outSof,
  output logic                    outEol,
  output logic [PIX_W-1:0]        outData,
  output logic [4*PIX_W-1:0]      offsetsOut
);

  ctrlStrb_t strb;

  dark_offset_ctrl #(
    .ROW_W        (ROW_W),
    .INT_LOG2_MAX (INT_LOG2_MAX)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .inValid      (inValid),
    .inSof        (inSof),
    .inEol        (inEol),
    .cfgEnable    (cfgEnable),
    .cfgPhase     (cfgPhase),
    .cfgDarkStart (cfgDarkStart),
    .cfgDarkCount (cfgDarkCount),
    .cfgIntLog2   (cfgIntLog2),
    .strb         (strb)
  );

  dark_offset_dp #(
    .PIX_W        (PIX_W),
    .INT_LOG2_MAX (INT_LOG2_MAX),
    .WIN_LOG2_MAX (WIN_LOG2_MAX)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .inData     (inData),
    .cfgIntLog2 (cfgIntLog2),
    .cfgWinLog2 (cfgWinLog2),
    .outValid   (outValid),
    .outSof     (outSof),
    .outEol     (outEol),
    .outData    (outData),
    .offsetsOut (offsetsOut)
  );

endmodule

// File: rtl/dark_offset_sub_chk.sv
module dark_offset_sub_chk #(
  parameter int PIX_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               inSof,
  input logic [PIX_W-1:0]   inData,
  input logic               cfgEnable,
  input logic               outValid,
  input logic               outSof,
  input logic               outEol,
  input logic [PIX_W-1:0]   outData,
  input logic [4*PIX_W-1:0] offsetsOut
);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outData <= $past(inData)));  // R7

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));  // R1

  AST_SYNC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (outSof || outEol) |-> outValid);  // R2

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgEnable && !(inValid && inSof)) |=> $stable(offsetsOut));  // R6

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> (offsetsOut == '0));  // R8

endmodule

bind dark_offset_sub dark_offset_sub_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .inSof      (inSof),
  .inData     (inData),
  .cfgEnable  (cfgEnable),
  .outValid   (outValid),
  .outSof     (outSof),
  .outEol     (outEol),
  .outData    (outData),
  .offsetsOut (offsetsOut)
);

// File: tb/test_dark_offset_sub.sv
module test_dark_offset_sub;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;
  localparam int COLS = 8;
  localparam int ROWS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEol = 1'b0;
  logic [PW-1:0] inData = '0;
  logic cfgEnable = 1'b0;
  logic [1:0] cfgPhase = '0;
  logic [10:0] cfgDarkStart = '0, cfgDarkCount = '0;
  logic [2:0] cfgIntLog2 = '0;
  logic [3:0] cfgWinLog2 = '0;
  logic outValid, outSof, outEol;
  logic [PW-1:0] outData;
  logic [4*PW-1:0] offsetsOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dark_offset_sub i_dark_offset_sub (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inEol(inEol),
    .inData(inData), .cfgEnable(cfgEnable), .cfgPhase(cfgPhase),
    .cfgDarkStart(cfgDarkStart), .cfgDarkCount(cfgDarkCount),
    .cfgIntLog2(cfgIntLog2), .cfgWinLog2(cfgWinLog2),
    .outValid(outValid), .outSof(outSof), .outEol(outEol),
    .outData(outData), .offsetsOut(offsetsOut)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  bit expValid, expSof, expEol;
  int expData;
  int mRow, mCol, mFrames;
  bit mArmed, mSofPend;
  int mAcc[4], mCnt[4], mOff[4];
  int lvl[4];

  function automatic int pickOff(input int c);
    return int'(offsetsOut[c*PW +: PW]);
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic modelDisable();
    mArmed = 0; mFrames = 0;
    for (int c = 0; c < 4; c++) begin mAcc[c] = 0; mCnt[c] = 0; mOff[c] = 0; end
  endtask

  task automatic modelStep(input int pix, input bit sof, input bit eol);
    int ch; bit dark; bit restart;
    if (sof) begin mRow = 0; mCol = 0; end
    ch = int'(cfgPhase) ^ (((mRow & 1) << 1) | (mCol & 1));
    dark = (mRow >= int'(cfgDarkStart)) && (mRow < int'(cfgDarkStart) + int'(cfgDarkCount));
    restart = 0;
    if (cfgEnable) begin
      if (sof) begin
        if (!mArmed) begin mArmed = 1; mFrames = 0; restart = 1; end
        else if (mFrames + 1 == (1 << cfgIntLog2)) begin
          for (int c = 0; c < 4; c++) mOff[c] = mAcc[c] >> (int'(cfgIntLog2) + int'(cfgWinLog2));
          mFrames = 0; restart = 1;
        end else mFrames++;
        for (int c = 0; c < 4; c++) mCnt[c] = 0;
        if (restart) for (int c = 0; c < 4; c++) mAcc[c] = 0;
      end
      if (mArmed && dark && mCnt[ch] < (1 << cfgWinLog2)) begin
        mAcc[ch] += pix; mCnt[ch]++;
      end
    end
    expValid = !dark;
    expEol = !dark && eol;
    expSof = !dark && (sof || mSofPend);
    if (!dark) mSofPend = 0; else if (sof) mSofPend = 1;
    expData = (pix > mOff[ch]) ? pix - mOff[ch] : 0;
    if (eol) begin mRow++; mCol = 0; end else mCol++;
  endtask

  // one clock: check the result of the previous cycle, then drive the next
  task automatic cycle(input bit v, input int pix, input bit sof, input bit eol);
    @(negedge clk);
    checks++;
    if (outValid !== expValid) fail("R1", "outValid", int'(outValid), int'(expValid));
    else if (expValid) begin
      if (int'(outData) != expData) fail("R7", "outData", int'(outData), expData);
      else if (outSof !== expSof) fail("R2", "outSof", int'(outSof), int'(expSof));
      else if (outEol !== expEol) fail("R2", "outEol", int'(outEol), int'(expEol));
    end
    checks++;
    for (int c = 0; c < 4; c++)
      if (pickOff(c) != mOff[c]) begin fail("R6", "offset held", pickOff(c), mOff[c]); break; end
    inValid = v; inSof = sof; inEol = eol; inData = PW'(pix);
    if (v) modelStep(pix, sof, eol);
    else begin expValid = 0; expSof = 0; expEol = 0; end
  endtask

  task automatic checkOffsets(input string req);
    cycle(0, 0, 0, 0);
    for (int c = 0; c < 4; c++) begin
      checks++;
      if (pickOff(c) != mOff[c]) fail(req, $sformatf("offset ch%0d", c), pickOff(c), mOff[c]);
    end
  endtask

  task automatic sendFrame(input bit smallActive);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int ch, pix;
        ch = int'(cfgPhase) ^ (((r & 1) << 1) | (c & 1));
        if (r >= int'(cfgDarkStart) && r < int'(cfgDarkStart) + int'(cfgDarkCount))
          pix = lvl[ch] + int'($urandom % 16);
        else pix = smallActive ? int'($urandom % 64) : int'($urandom % 4096);
        if ($urandom % 8 == 0) cycle(0, 0, 0, 0);
        cycle(1, pix, (r == 0 && c == 0), (c == COLS - 1));
      end
  endtask

  task automatic setCfg(input int ph, input int ds, input int dc, input int k, input int w);
    @(negedge clk);
    cfgEnable = 0; inValid = 0; modelDisable();
    expValid = 0;
    cycle(0, 0, 0, 0);
    cfgPhase = 2'(ph); cfgDarkStart = 11'(ds); cfgDarkCount = 11'(dc);
    cfgIntLog2 = 3'(k); cfgWinLog2 = 4'(w); cfgEnable = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelDisable(); mSofPend = 0; mRow = 0; mCol = 0;
    expValid = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outSof !== 1'b0 || outEol !== 1'b0 || offsetsOut !== '0)
      fail("R9", "reset outputs", int'(outValid), 0);

    // R3 R5: phase 0, top dark band, exact window, two-frame period
    lvl = '{100, 200, 300, 400};
    setCfg(0, 0, 2, 1, 2);
    repeat (3) sendFrame(0);
    checkOffsets("R5");

    // R3 R4: phase 3, bottom band, window smaller than supply
    lvl = '{50, 900, 1500, 3000};
    setCfg(3, 5, 3, 0, 1);
    repeat (2) sendFrame(1);
    checkOffsets("R4");
    checkOffsets("R3");

    // R10: new levels in a following period replace the old set
    lvl = '{10, 20, 30, 40};
    repeat (2) sendFrame(1);
    checkOffsets("R10");

    // R8: disable clears offsets and passes pixels unchanged
    @(negedge clk);
    cfgEnable = 0; inValid = 0; modelDisable(); expValid = 0;
    checkOffsets("R8");
    sendFrame(0);
    checkOffsets("R8");

    // random configurations
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < 4; c++) lvl[c] = int'($urandom % 2000);
      setCfg(int'($urandom % 4), int'($urandom % 6), int'($urandom % 3),
             int'($urandom % 3), int'($urandom % 4));
      for (int f = 0; f < 5; f++) sendFrame($urandom % 2 == 0);
      checkOffsets("R5");
    end

    cycle(0, 0, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule